// File: doc/BRIEF.md
# Instruction-to-Data Block Copy Controller

This controller moves a fixed-length block of words from a source memory into a destination memory. By default it copies the 256 instruction words at 0x0000–0x00FF into the data words at 0x8000–0x80FF. It drives the read port of the source RAM and the write port of the destination RAM.

Both RAMs are synchronous, so a word becomes available one cycle after its address is presented. The controller keeps two address counters, each with its own incrementer. The destination counter trails the source counter by one word. After a single priming read, every cycle writes the word fetched in the previous cycle while it fetches the next one.

A one-cycle start pulse launches the copy. A status flag reports success or failure and holds until the next start. An error reported by either memory aborts the copy at once.

Top module: `blk_copy_fsm`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `error`, `src_rd_en` and `dst_wr_en` are all low.
- R2: A start pulse while idle puts `src_rd_en` high in the next cycle with `src_addr` = SRC_BASE (0x0000), and `busy` goes high.
- R3: Each cycle with `dst_wr_en` high carries in `dst_wdata` the source word read in the previous cycle. Its `dst_addr` is DST_BASE (0x8000) plus the word index, rising by one per write, so no word is skipped or duplicated.
- R4: A full copy performs exactly COUNT (256) reads and COUNT writes. The last read is at address 0x00FF and no read falls outside the source range. `done` is first high COUNT+2 cycles after the start cycle.
- R5: After a successful copy, `done` stays high and `busy` and `error` stay low until the next start.
- R6: A start pulse during a copy is ignored: the copy continues unchanged and still writes each destination word exactly once.
- R7: If `src_err` is high in a write cycle, that word is not written (`dst_wr_en` low). The copy stops and `error` stays high (with `busy` and `done` low) until the next start.
- R8: If `dst_err` is high during a write, the copy stops after that cycle and `error` stays high until the next start. No further writes occur.
- R9: A start pulse from the done or error state clears the flag and runs a fresh complete copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse |
| src_rd_en | output | 1 | Source read strobe |
| src_addr | output | AW (16) | Source read address |
| src_rdata | input | DW (16) | Source read data, valid one cycle after the strobe |
| src_err | input | 1 | Source error, valid together with the read data |
| dst_wr_en | output | 1 | Destination write strobe |
| dst_addr | output | AW (16) | Destination write address |
| dst_wdata | output | DW (16) | Destination write data |
| dst_err | input | 1 | Destination error for the current write |
| busy | output | 1 | Copy in progress |
| done | output | 1 | Last copy finished cleanly |
| error | output | 1 | Last copy aborted on a memory error |

## Verification
The copy is run with a random source image, with an image derived from each word's address, and with alternating all-ones/all-zeros words. The random image exposes data taken from the wrong read cycle. The address-derived image exposes an off-by-one between the two counters. The alternating image exposes a stuck or shifted data bit.

Each destination word is written exactly once, counted per address. The read count and the last read address confirm the exact termination point. A start pulse in the middle of a copy must leave the result unchanged.

Errors are injected from the source in the middle of the range and from the destination near the bottom. These runs check that the copy stops at the right word and that the error flag holds. A restart after each abort must complete cleanly.

// File: rtl/blk_copy_fsm.sv
module blk_copy_fsm #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int COUNT = 256,
  parameter logic [15:0] SRC_BASE = 16'h0000,
  parameter logic [15:0] DST_BASE = 16'h8000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          src_rd_en,
  output logic [AW-1:0] src_addr,
  input  logic [DW-1:0] src_rdata,
  input  logic          src_err,
  output logic          dst_wr_en,
  output logic [AW-1:0] dst_addr,
  output logic [DW-1:0] dst_wdata,
  input  logic          dst_err,
  output logic          busy,
  output logic          done,
  output logic          error
);
  localparam int CW = $clog2(COUNT) + 1;
  localparam logic [CW-1:0] LAST = CW'(COUNT - 1);
  localparam logic [CW-1:0] FULL = CW'(COUNT);

  typedef enum logic [2:0] {S_IDLE, S_READ, S_WRITE, S_DONE, S_FAULT} state_t;

  state_t        state;
  logic [CW-1:0] src_cnt, dst_cnt;
  logic          in_write, wr_fault;

  assign in_write  = (state == S_WRITE);
  assign src_rd_en = (state == S_READ) || (in_write && src_cnt != FULL);
  assign src_addr  = SRC_BASE[AW-1:0] + AW'(src_cnt);
  assign dst_wr_en = in_write && !src_err;
  assign dst_addr  = DST_BASE[AW-1:0] + AW'(dst_cnt);
  assign dst_wdata = src_rdata;
  assign wr_fault  = in_write && (src_err || dst_err);
  assign busy      = (state == S_READ) || in_write;
  assign done      = (state == S_DONE);
  assign error     = (state == S_FAULT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      src_cnt <= '0;
      dst_cnt <= '0;
    end else begin
      if (src_rd_en && !wr_fault) src_cnt <= src_cnt + 1'b1;
      if (in_write && !wr_fault) dst_cnt <= dst_cnt + 1'b1;
      case (state)
        S_IDLE, S_DONE, S_FAULT:
          if (start) begin
            state   <= S_READ;
            src_cnt <= '0;
            dst_cnt <= '0;
          end
        S_READ:  state <= S_WRITE;
        S_WRITE:
          if (wr_fault)               state <= S_FAULT;
          else if (dst_cnt == LAST)   state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module blk_copy_fsm_chk #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int COUNT = 256,
  parameter logic [15:0] SRC_BASE = 16'h0000,
  parameter logic [15:0] DST_BASE = 16'h8000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          src_rd_en,
  input logic [AW-1:0] src_addr,
  input logic [DW-1:0] src_rdata,
  input logic          src_err,
  input logic          dst_wr_en,
  input logic [AW-1:0] dst_addr,
  input logic          dst_err,
  input logic          busy,
  input logic          done,
  input logic          error
);
  p_start_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (src_rd_en && src_addr == SRC_BASE[AW-1:0] && busy));
  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_wr_en && $past(dst_wr_en)) |-> (dst_addr == $past(dst_addr) + 1'b1));
  p_rd_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    src_rd_en |-> ((src_addr - SRC_BASE[AW-1:0]) < AW'(COUNT)));
  p_flags_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({busy, done, error}) <= 1);
  p_done_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
  p_busy_stays_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !src_err && !dst_err && !$fell(src_rd_en)) |=> busy);
  p_src_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !src_rd_en && src_err) |-> !dst_wr_en);
  p_src_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(src_rd_en) && src_err) |=> (error && !busy));
  p_dst_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_wr_en && dst_err) |=> (error && !dst_wr_en));
  p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (error && !start) |=> error);
endmodule

bind blk_copy_fsm blk_copy_fsm_chk #(
  .AW(AW), .DW(DW), .COUNT(COUNT), .SRC_BASE(SRC_BASE), .DST_BASE(DST_BASE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .src_rd_en(src_rd_en),
  .src_addr(src_addr), .src_rdata(src_rdata), .src_err(src_err),
  .dst_wr_en(dst_wr_en), .dst_addr(dst_addr), .dst_err(dst_err),
  .busy(busy), .done(done), .error(error)
);

// File: tb/blk_copy_fsm_tb_top.sv
module blk_copy_fsm_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 256;

  logic        clk = 0, rst_n = 0, start = 0;
  logic        src_rd_en, dst_wr_en, busy, done, error;
  logic [15:0] src_addr, dst_addr, dst_wdata;
  logic [15:0] src_rdata = '0;
  logic        src_err = 0, dst_err;

  logic [15:0] smem [N];
  logic [15:0] dmem [N];
  int          wcnt [N];
  int          rd_count = 0, wr_count = 0;
  logic [15:0] last_rd = '0;
  logic        inj_src = 0, inj_dst = 0;
  logic [15:0] inj_src_addr = '0, inj_dst_addr = '0;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_copy_fsm dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .src_rd_en(src_rd_en), .src_addr(src_addr), .src_rdata(src_rdata), .src_err(src_err),
    .dst_wr_en(dst_wr_en), .dst_addr(dst_addr), .dst_wdata(dst_wdata), .dst_err(dst_err),
    .busy(busy), .done(done), .error(error)
  );

  assign dst_err = dst_wr_en && inj_dst && (dst_addr == inj_dst_addr);

  always @(posedge clk) begin
    src_err <= 1'b0;
    if (src_rd_en) begin
      src_rdata <= smem[src_addr[7:0]];
      src_err   <= (inj_src && src_addr == inj_src_addr) || (src_addr[15:8] != 8'h00);
      rd_count  <= rd_count + 1;
      last_rd   <= src_addr;
    end
    if (dst_wr_en && !dst_err) begin
      if (dst_addr[15:8] == 8'h80) begin
        dmem[dst_addr[7:0]] <= dst_wdata;
        wcnt[dst_addr[7:0]] <= wcnt[dst_addr[7:0]] + 1;
      end
      wr_count <= wr_count + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pattern(input int mode, input int i);
    case (mode)
      0: return 16'($urandom);
      1: return 16'(i) ^ 16'hA5C3 ^ 16'(i << 8);
      default: return (i % 2 == 0) ? 16'hFFFF : 16'h0000;
    endcase
  endfunction

  task automatic prep(input int mode);
    for (int i = 0; i < N; i++) begin
      smem[i] = pattern(mode, i);
      dmem[i] = 16'hDEAD;
      wcnt[i] = 0;
    end
    @(negedge clk);
    rd_count = 0;
    wr_count = 0;
  endtask

  task automatic pulse_start();
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_end(output int n);
    n = 1;
    while (!done && !error && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic check_image(input string req, input int upto);
    int bad = 0, dup = 0;
    for (int i = 0; i < N; i++) begin
      logic [15:0] e = (i < upto) ? smem[i] : 16'hDEAD;
      if (dmem[i] !== e) bad++;
      if (wcnt[i] != ((i < upto) ? 1 : 0)) dup++;
    end
    check({req, " data mismatches"}, bad, 0);
    check({req, " write-once"}, dup, 0);
  endtask

  task automatic full_run(input int mode, input bit mid_start);
    int n;
    prep(mode);
    start = 1;
    @(negedge clk);
    start = 0;
    check("R2 rd_en after start", src_rd_en, 1);
    check("R2 first addr", src_addr, 16'h0000);
    check("R2 busy", busy, 1);
    if (mid_start) begin
      repeat (50) @(negedge clk);
      pulse_start();
      n = 52;
      while (!done && !error && n < 2000) begin @(negedge clk); n++; end
    end else begin
      wait_end(n);
    end
    check("R4 cycles to done", n, N + 2);
    check("R4 read count", rd_count, N);
    check("R4 write count", wr_count, N);
    check("R4 last read addr", last_rd, 16'h00FF);
    check_image(mid_start ? "R6" : "R3", N);
    repeat (5) @(negedge clk);
    check("R5 done held", {done, busy, error}, 3'b100);
  endtask

  initial begin
    int n;
    void'($urandom(32'h1234));
    repeat (3) @(negedge clk);
    check("R1 reset flags", {busy, done, error, src_rd_en, dst_wr_en}, 5'b0);
    rst_n = 1;
    @(negedge clk);
    check("R1 idle after reset", {busy, done, error, src_rd_en, dst_wr_en}, 5'b0);

    full_run(0, 0);
    full_run(1, 0);
    full_run(2, 0);
    full_run(0, 1);

    prep(1);
    inj_src = 1; inj_src_addr = 16'h0040;
    pulse_start();
    wait_end(n);
    repeat (4) @(negedge clk);
    check("R7 error flags", {busy, done, error}, 3'b001);
    check("R7 writes before abort", wr_count, 64);
    check_image("R7", 64);
    inj_src = 0;

    full_run(0, 0);
    check("R9 restart after fault", {done, error}, 2'b10);

    prep(0);
    inj_dst = 1; inj_dst_addr = 16'h8010;
    pulse_start();
    wait_end(n);
    repeat (4) @(negedge clk);
    check("R8 error flags", {busy, done, error}, 3'b001);
    check("R8 accepted writes", wr_count, 16);
    check("R8 no write strobe", dst_wr_en, 0);
    check_image("R8", 16);
    inj_dst = 0;

    full_run(1, 0);
    check("R9 restart clears error", error, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule